// File: doc/BRIEF.md
# Filtered Channel Interrupt Combiner

This block gathers one active-low interrupt request line from each downstream channel and merges them into a single request toward the upstream host. Each line first crosses into the system clock domain through a two-stage synchronizer. A persistence filter then decides whether the line has really changed level. A drop to low must last a minimum number of clock cycles before it counts as a request. A return to high must last a separate, shorter minimum before the request counts as withdrawn. Both minimums are given in nanoseconds and converted into clock cycles at elaboration.

The filtered requests feed two consumers. The first is a per-channel pending vector that the neighbouring control register places in its upper nibble: channel n goes to register bit 4+n. The second is one drive-low enable for a shared open-drain request wire. The channel-select state of the switch plays no part, so a request is seen on every channel whether that channel is routed or not. A request is withdrawn only when the external device lets its own line return high. When a register read begins, the pending vector is copied into a held snapshot, which keeps the byte being shifted out stable.

Top module: `irq_combiner`

## Requirements
- R1: `irq_drive_low` is 1 while at least one channel's filtered request is pending and 0 when none is. This is the AND of the active-low filtered lines, expressed as a drive enable.
- R2: `pending` bit n is 1 exactly while channel n's filtered request is asserted. Bit n is channel n, which the register neighbour places at bit 4+n.
- R3: A low level on an input lasting fewer than `LOW_CYC` clock cycles (1000 ns by default, 250 cycles at 250 MHz) is rejected and leaves the outputs unchanged. A low level held for at least `LOW_CYC` cycles is accepted.
- R4: While a request is pending, a high level on that input lasting fewer than `HIGH_CYC` cycles (500 ns by default, 125 cycles) is rejected and the request stays asserted.
- R5: A request asserts `LOW_CYC`+2 cycles after the input falls, which is within 4 µs. It releases `HIGH_CYC`+2 cycles after the input rises, which is within 2 µs.
- R6: During and directly after reset every filtered request is deasserted, `irq_drive_low` is 0 and `held` is 0, whatever the input levels.
- R7: `held` loads `pending` on the clock edge where `snap` is 1 and does not change on any other edge.
- R8: Channels are filtered independently: activity on one input does not change the pending bit of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in_n | input | NUM_CH | Active-low request lines, one per channel, asynchronous |
| snap | input | 1 | One-cycle pulse at the start of a register read |
| pending | output | NUM_CH | Live filtered request per channel, 1 = pending |
| held | output | NUM_CH | Snapshot of `pending` taken at the last `snap` |
| irq_drive_low | output | 1 | 1 = pull the shared open-drain request wire low |

## Verification
The filter assertions assume that the synchronized level feeding each filter has settled at every clock edge. They also assume that `snap` is a synchronous single-cycle strobe. The bench drives every input and `snap` on the falling clock edge, so both assumptions hold and pulse widths are exact whole cycles. Pulse widths that test rejection and acceptance are kept a few cycles away from each threshold. The release bound is measured from the last input to rise.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  // Convert a duration in nanoseconds to clock cycles, rounding up, min 1.
  function automatic int ns_to_cyc(input longint clk_hz, input longint ns);
    longint c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  // Reset to the idle (high) level so nothing looks pending out of reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irqf_deglitch.sv
module irqf_deglitch #(
  parameter int LOW_CYC  = 250,
  parameter int HIGH_CYC = 125,
  parameter int CW       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic filt_o,
  output logic flip_o
);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  logic          filt_q;
  logic [CW-1:0] run_q;
  logic          differ;
  logic [CW-1:0] last;

  assign differ = (sync_i != filt_q);
  // A line that is high now needs the long low run before it counts as low.
  assign last   = filt_q ? LOW_LAST : HIGH_LAST;
  assign flip_o = differ && (run_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      run_q  <= '0;
    end else if (!differ) begin
      run_q  <= '0;
    end else if (flip_o) begin
      filt_q <= sync_i;
      run_q  <= '0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R3: a falling filtered level requires the synchronized input to have been low.
  p_fall_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> !$past(sync_i));
  // R4: a rising filtered level requires the synchronized input to have been high.
  p_rise_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> $past(sync_i));
  // R3: the run counter never passes the larger threshold.
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LOW_LAST || run_q <= HIGH_LAST);
  // R5: while input and filter agree, the filter holds its level.
  p_hold_when_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/irqf_snap.sv
module irqf_snap #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_i,
  input  logic [WIDTH-1:0] live_i,
  output logic [WIDTH-1:0] held_o
);
  logic [WIDTH-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= '0;
    else if (snap_i) held_q <= live_i;
  end

  assign held_o = held_q;

  // R7: capture on the strobe edge.
  p_snap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> held_q == $past(live_i));
  // R7: unchanged without a strobe.
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(held_q));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqf_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CLK_HZ      = 250_000_000,
  parameter int LOW_REJ_NS  = 1000,
  parameter int HIGH_REJ_NS = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in_n,
  input  logic              snap,
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] held,
  output logic              irq_drive_low
);
  localparam int LOW_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(LOW_REJ_NS));
  localparam int HIGH_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(HIGH_REJ_NS));
  localparam int CW       = $clog2(max_int(LOW_CYC, HIGH_CYC) + 1);

  logic [NUM_CH-1:0] sync_lvl;
  logic [NUM_CH-1:0] filt_lvl;
  logic [NUM_CH-1:0] flip_evt;

  irqf_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_in_n), .sync_o(sync_lvl)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    irqf_deglitch #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .CW(CW)) u_flt (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_lvl[ch]),
      .filt_o(filt_lvl[ch]), .flip_o(flip_evt[ch])
    );
  end

  assign pending       = ~filt_lvl;
  assign irq_drive_low = ~&filt_lvl;

  irqf_snap #(.WIDTH(NUM_CH)) u_snap (
    .clk(clk), .rst_n(rst_n), .snap_i(snap), .live_i(pending), .held_o(held)
  );

  // R8: a channel's pending bit only moves when that channel's filter flips.
  p_move_needs_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_evt == '0) |=> $stable(pending));
  // R1: the request wire rises only when some filter has just flipped.
  p_rise_from_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_drive_low) |-> $past(flip_evt) != '0);
  // R6: immediately after reset nothing is pending.
  p_reset_idle_r6: assert property (@(posedge clk)
    $rose(rst_n) |-> (pending == '0 && held == '0 && !irq_drive_low));
endmodule

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
  localparam int NCH  = 4;
  localparam int LOWC = 250;   // 1000 ns at 250 MHz
  localparam int HIC  = 125;   // 500 ns at 250 MHz

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] irq_in_n = '1;
  logic           snap = 1'b0;
  logic [NCH-1:0] pending, held;
  logic           irq_drive_low;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_combiner uut (
    .clk(clk), .rst_n(rst_n), .irq_in_n(irq_in_n), .snap(snap),
    .pending(pending), .held(held), .irq_drive_low(irq_drive_low)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    irq_in_n = 4'b0000;               // lines low during reset: R6
    rst_n = 1'b0;
    idle(5);
    chk("R6 drive in reset", irq_drive_low, 0);
    chk("R6 pending in reset", pending, 0);
    irq_in_n = '1;
    rst_n = 1'b1;
    idle(1);
    chk("R6 held after reset", held, 0);
    chk("R6 drive after reset", irq_drive_low, 0);
    idle(HIC + 10);
  endtask

  task automatic t_short_low();
    int seen = 0;
    irq_in_n[0] = 1'b0;
    for (int i = 0; i < LOWC - 3; i++) begin
      @(negedge clk);
      if (irq_drive_low) seen = 1;
    end
    irq_in_n[0] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_drive_low || pending != 0) seen = 1;
    end
    chk("R3 short low rejected", seen, 0);
  endtask

  task automatic t_long_low();
    int lat = 0;
    irq_in_n[1] = 1'b0;
    while (!irq_drive_low && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 assert latency", lat, LOWC + 2);
    chk("R5 assert under 4us", int'(lat <= 1000), 1);
    chk("R2 pending ch1", pending, 4'b0010);
    chk("R1 drive with one pending", irq_drive_low, 1);
  endtask

  task automatic t_high_glitch_then_release();
    int drop = 0;
    int lat = 0;
    irq_in_n[1] = 1'b1;
    for (int i = 0; i < HIC - 3; i++) begin
      @(negedge clk);
      if (!irq_drive_low) drop = 1;
    end
    irq_in_n[1] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!irq_drive_low) drop = 1;
    end
    chk("R4 high glitch rejected", drop, 0);
    irq_in_n[1] = 1'b1;
    while (irq_drive_low && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 release latency", lat, HIC + 2);
    chk("R5 release under 2us", int'(lat <= 500), 1);
    chk("R2 pending clear", pending, 0);
  endtask

  task automatic t_multi();
    irq_in_n[0] = 1'b0;
    irq_in_n[3] = 1'b0;
    idle(LOWC + 6);
    chk("R2 pending ch0 ch3", pending, 4'b1001);
    irq_in_n[0] = 1'b1;
    idle(HIC + 6);
    chk("R1 still driven by ch3", irq_drive_low, 1);
    chk("R8 ch3 kept after ch0 release", pending, 4'b1000);
    // R8: a short low on ch2 does not disturb ch3
    irq_in_n[2] = 1'b0;
    idle(10);
    irq_in_n[2] = 1'b1;
    idle(20);
    chk("R8 ch2 glitch isolated", pending, 4'b1000);
    irq_in_n[3] = 1'b1;
    idle(HIC + 6);
    chk("R1 released when none pending", irq_drive_low, 0);
  endtask

  task automatic t_snapshot();
    irq_in_n[2] = 1'b0;
    idle(LOWC + 6);
    snap = 1'b1;
    idle(1);
    snap = 1'b0;
    chk("R7 held captured", held, 4'b0100);
    irq_in_n[2] = 1'b1;
    idle(HIC + 6);
    chk("R7 live cleared", pending, 0);
    chk("R7 held stable without strobe", held, 4'b0100);
    snap = 1'b1;
    idle(1);
    snap = 1'b0;
    chk("R7 held recaptured", held, 0);
  endtask

  task automatic t_reset_mid();
    irq_in_n[0] = 1'b0;
    idle(LOWC + 6);
    chk("R1 pending before reset", irq_drive_low, 1);
    rst_n = 1'b0;
    idle(2);
    chk("R6 reset releases drive", irq_drive_low, 0);
    irq_in_n[0] = 1'b1;
    rst_n = 1'b1;
    idle(4);
    chk("R6 pending after reset", pending, 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset();
        t_short_low();
        t_long_low();
        t_high_glitch_then_release();
        t_multi();
        t_snapshot();
        t_reset_mid();
      end
      begin
        idle(100_000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule